// File: doc/BRIEF.md
# Frame Statistics Counters with Half-Range Interrupts

This block keeps four frame statistics counters for a network MAC: three on the receive side and one on the transmit side. The receive counters track good unicast frames, frames with a bad CRC, and frames with an alignment fault. The transmit counter tracks good frames sent. Each event comes in as a single-cycle pulse on its own pin. When a counter's most significant bit turns on, meaning it has reached half of its range, a sticky status bit latches. That bit drops only when software reads the counter with byte lane 0 enabled.

Software reaches the counters, the two status words and two mask words through a simple single-cycle register port. The port has an address, byte enables, separate read and write strobes, and read data that is registered and returned one cycle after the strobe. Two level interrupt outputs, one for receive and one for transmit, are each the OR of that side's status bits whose mask bit is clear.

There is no streaming data path, so there is no valid/ready pair and no back-pressure. Event pins and the register port are plain signals, and the block accepts a strobe or pulse on every cycle.

Top module: `mac_stat_irq`

## Requirements
- R1: After reset, every counter, both status words and both mask words read 0x0000_0000, and `irq_rx` and `irq_tx` are low.
- R2: Each counter adds one in the clock edge where its event pin is high, and wraps from all ones to zero. A counter read returns the value held before that edge, zero-extended to 32 bits. Counter addresses: 0x120 unicast, 0x124 CRC error, 0x128 alignment error, 0x12C transmit good.
- R3: A status bit sets in the edge where its counter's most significant bit goes from 0 to 1. Receive status (0x104): bit 17 unicast, bit 6 alignment error, bit 5 CRC error. Transmit status (0x108): bit 21 transmit good.
- R4: A status bit clears when its counter is read with `bus_be[0]` high. A read of that counter with `bus_be[0]` low leaves the bit set.
- R5: If a clearing read and a set condition for the same bit fall in the same cycle, the bit ends up set.
- R6: Status words are read-only, so a write to 0x104 or 0x108 changes nothing. Status bit positions other than those in R3 always read as zero.
- R7: Mask words are 0x10C (receive) and 0x110 (transmit). Only the bit positions listed in R3 are stored; all other bits read as zero. A write updates only the byte lanes whose `bus_be` bit is high.
- R8: `irq_rx` is high exactly when some receive status bit is set and its mask bit is 0. `irq_tx` follows the same rule for the transmit side.
- R9: `bus_rdata` carries read data in the cycle after `bus_rd`. Byte lanes not enabled in `bus_be` read as zero. Unmapped addresses read as zero, and `bus_rdata` is zero in any cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_ucast_ok | input | 1 | Pulse: good unicast frame received |
| rx_crc_bad | input | 1 | Pulse: frame received with CRC error |
| rx_align_bad | input | 1 | Pulse: frame received with alignment error |
| tx_frame_ok | input | 1 | Pulse: good frame transmitted |
| bus_addr | input | 12 | Register byte address |
| bus_be | input | 4 | Byte lane enables |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after `bus_rd` |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |

## Verification
The bench builds the block with `CNT_W` = 8 instead of the default 32. With that setting the half-range point is 128 pulses and a full wrap is 256 pulses, so the set edge, the set-versus-clear collision and the all-ones-to-zero wrap can all be reached in a few hundred cycles. The register layout and the status bit positions do not depend on `CNT_W`, so the map, the lane handling and the masks are exercised exactly as they are at full width.

// File: rtl/mac_stat_pkg.sv
package mac_stat_pkg;
  localparam int AW      = 12;
  localparam int DW      = 32;
  localparam int LANES   = DW / 8;
  localparam int NUM_CNT = 4;

  localparam logic [AW-1:0] A_STS_RX  = 12'h104;
  localparam logic [AW-1:0] A_STS_TX  = 12'h108;
  localparam logic [AW-1:0] A_MSK_RX  = 12'h10C;
  localparam logic [AW-1:0] A_MSK_TX  = 12'h110;

  // counter order: unicast, crc, align, tx good
  localparam logic [AW-1:0] A_CNT [NUM_CNT] = '{12'h120, 12'h124, 12'h128, 12'h12C};
  localparam int            STS_POS [NUM_CNT] = '{17, 5, 6, 21};
  localparam bit            ON_TX   [NUM_CNT] = '{1'b0, 1'b0, 1'b0, 1'b1};

  localparam logic [DW-1:0] RX_LIVE = 32'h0002_0060;
  localparam logic [DW-1:0] TX_LIVE = 32'h0020_0000;
endpackage

// File: rtl/stat_cell.sv
module stat_cell #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             rd_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             flag
);
  localparam logic [CNT_W-1:0] BELOW_HALF = {1'b0, {(CNT_W-1){1'b1}}};

  logic msb_rise;
  assign msb_rise = evt && (cnt == BELOW_HALF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (evt) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (msb_rise) begin
      flag <= 1'b1;
    end else if (rd_clr) begin
      flag <= 1'b0;
    end
  end

  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    evt && (&cnt) |=> cnt == '0);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> $stable(cnt));
  a_r3_set_on_msb: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnt[CNT_W-1]) |-> flag);
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr && !msb_rise |=> !flag);
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr && msb_rise |=> flag);
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !rd_clr |=> flag);
endmodule

// File: rtl/stat_mask_ctl.sv
module stat_mask_ctl
  import mac_stat_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_rx,
  input  logic          wr_tx,
  input  logic [LANES-1:0] be,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] sts_rx,
  input  logic [DW-1:0] sts_tx,
  output logic [DW-1:0] mask_rx,
  output logic [DW-1:0] mask_tx,
  output logic          irq_rx,
  output logic          irq_tx
);
  logic [DW-1:0] nxt_rx, nxt_tx;

  always_comb begin
    nxt_rx = mask_rx;
    nxt_tx = mask_tx;
    for (int b = 0; b < LANES; b++) begin
      if (be[b]) begin
        nxt_rx[8*b +: 8] = wdata[8*b +: 8];
        nxt_tx[8*b +: 8] = wdata[8*b +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_rx <= '0;
      mask_tx <= '0;
    end else begin
      if (wr_rx) mask_rx <= nxt_rx & RX_LIVE;
      if (wr_tx) mask_tx <= nxt_tx & TX_LIVE;
    end
  end

  assign irq_rx = |(sts_rx & ~mask_rx);
  assign irq_tx = |(sts_tx & ~mask_tx);

  a_r7_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_rx |=> $stable(mask_rx));
  a_r7_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_tx |=> $stable(mask_tx));
  a_r8_rx_src: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |-> sts_rx != '0);
  a_r8_tx_src: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx |-> sts_tx != '0);
endmodule

// File: rtl/mac_stat_irq.sv
module mac_stat_irq
  import mac_stat_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_ucast_ok,
  input  logic          rx_crc_bad,
  input  logic          rx_align_bad,
  input  logic          tx_frame_ok,
  input  logic [AW-1:0] bus_addr,
  input  logic [3:0]    bus_be,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_rx,
  output logic          irq_tx
);
  logic [NUM_CNT-1:0] evt, rd_clr, flag;
  logic [CNT_W-1:0]   cnt_q [NUM_CNT];
  logic [DW-1:0]      sts_rx, sts_tx, mask_rx, mask_tx;
  logic [DW-1:0]      rd_mux, lane_m;

  assign evt = {tx_frame_ok, rx_align_bad, rx_crc_bad, rx_ucast_ok};

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cell
    assign rd_clr[i] = bus_rd && bus_be[0] && (bus_addr == A_CNT[i]);
    stat_cell #(.CNT_W(CNT_W)) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (evt[i]),
      .rd_clr (rd_clr[i]),
      .cnt    (cnt_q[i]),
      .flag   (flag[i])
    );
  end

  always_comb begin
    sts_rx = '0;
    sts_tx = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (ON_TX[i]) sts_tx[STS_POS[i]] = flag[i];
      else          sts_rx[STS_POS[i]] = flag[i];
    end
  end

  stat_mask_ctl u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_rx   (bus_wr && bus_addr == A_MSK_RX),
    .wr_tx   (bus_wr && bus_addr == A_MSK_TX),
    .be      (bus_be),
    .wdata   (bus_wdata),
    .sts_rx  (sts_rx),
    .sts_tx  (sts_tx),
    .mask_rx (mask_rx),
    .mask_tx (mask_tx),
    .irq_rx  (irq_rx),
    .irq_tx  (irq_tx)
  );

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign lane_m[8*b +: 8] = {8{bus_be[b]}};
  end

  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      A_STS_RX: rd_mux = sts_rx;
      A_STS_TX: rd_mux = sts_tx;
      A_MSK_RX: rd_mux = mask_rx;
      A_MSK_TX: rd_mux = mask_tx;
      default:  rd_mux = '0;
    endcase
    for (int i = 0; i < NUM_CNT; i++) begin
      if (bus_addr == A_CNT[i]) rd_mux[CNT_W-1:0] = cnt_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux & lane_m;
    else             bus_rdata <= '0;
  end

  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == '0);
  a_r6_rx_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_rx & ~RX_LIVE) == '0);
  a_r6_sts_ro: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == A_STS_TX && !tx_frame_ok && !bus_rd |=> $stable(sts_tx));
endmodule

// File: tb/sim_mac_stat_irq.sv
module sim_mac_stat_irq;
  localparam int CW = 8;

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VT [14] = '{
    '{1'b1, 12'h10C, 4'hF, 32'hFFFF_FFFF, 32'h0},          // R7
    '{1'b0, 12'h10C, 4'hF, 32'h0,         32'h0002_0060},  // R7
    '{1'b1, 12'h110, 4'hF, 32'hFFFF_FFFF, 32'h0},          // R7
    '{1'b0, 12'h110, 4'hF, 32'h0,         32'h0020_0000},  // R7
    '{1'b1, 12'h110, 4'h4, 32'h0,         32'h0},          // R7
    '{1'b0, 12'h110, 4'hF, 32'h0,         32'h0},          // R7
    '{1'b1, 12'h10C, 4'h1, 32'h0,         32'h0},          // R7
    '{1'b0, 12'h10C, 4'hF, 32'h0,         32'h0002_0000},  // R7
    '{1'b1, 12'h10C, 4'h4, 32'h0,         32'h0},          // R7
    '{1'b0, 12'h10C, 4'hF, 32'h0,         32'h0},          // R7
    '{1'b1, 12'h104, 4'hF, 32'hFFFF_FFFF, 32'h0},          // R6
    '{1'b0, 12'h104, 4'hF, 32'h0,         32'h0},          // R6
    '{1'b0, 12'h108, 4'h3, 32'h0,         32'h0},          // R6
    '{1'b0, 12'h000, 4'hF, 32'h0,         32'h0}           // R9
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_uc = 0, ev_crc = 0, ev_al = 0, ev_tx = 0;
  logic [11:0] addr = '0;
  logic [3:0]  be = '0;
  logic        rd = 0, wr = 0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_rx, irq_tx;
  int          n_cmp = 0, n_bad = 0;
  logic [31:0] got;

  always #4 clk = ~clk;

  mac_stat_irq #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .rx_ucast_ok(ev_uc), .rx_crc_bad(ev_crc), .rx_align_bad(ev_al), .tx_frame_ok(ev_tx),
    .bus_addr(addr), .bus_be(be), .bus_rd(rd), .bus_wr(wr), .bus_wdata(wdata),
    .bus_rdata(rdata), .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    addr = a; be = b; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, input logic [3:0] b, output logic [31:0] d);
    @(negedge clk);
    addr = a; be = b; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic pulse(input int which, input int n);
    @(negedge clk);
    case (which)
      0: ev_uc = 1'b1;
      1: ev_crc = 1'b1;
      2: ev_al = 1'b1;
      default: ev_tx = 1'b1;
    endcase
    repeat (n) @(negedge clk);
    ev_uc = 0; ev_crc = 0; ev_al = 0; ev_tx = 0;
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq_rx", {31'b0, irq_rx}, 32'h0);
    chk("R1 irq_tx", {31'b0, irq_tx}, 32'h0);
    for (int i = 0; i < 4; i++) begin
      bus_read(12'h120 + 12'(4 * i), 4'hF, got);
      chk("R1 counter", got, 32'h0);
    end
    bus_read(12'h104, 4'hF, got); chk("R1 rx status", got, 32'h0);
    bus_read(12'h108, 4'hF, got); chk("R1 tx status", got, 32'h0);

    // table walk: masks, read-only status, unmapped
    for (int k = 0; k < 14; k++) begin
      if (VT[k].wr) bus_write(VT[k].addr, VT[k].be, VT[k].wd);
      else begin
        bus_read(VT[k].addr, VT[k].be, got);
        chk("R6/R7/R9 table", got, VT[k].exp);
      end
    end

    // R2/R3 CRC counter to the half point
    pulse(1, 127);
    bus_read(12'h124, 4'hF, got); chk("R2 crc count", got, 32'h7F);
    bus_read(12'h104, 4'hF, got); chk("R3 below half", got, 32'h0);
    chk("R8 no irq yet", {31'b0, irq_rx}, 32'h0);
    pulse(1, 1);
    bus_read(12'h104, 4'hF, got); chk("R3 crc bit5", got, 32'h20);
    chk("R8 irq_rx high", {31'b0, irq_rx}, 32'h1);
    chk("R8 irq_tx low", {31'b0, irq_tx}, 32'h0);

    // R4 upper-lane read keeps, lane0 read clears; R9 lane masking
    bus_read(12'h124, 4'hE, got); chk("R9 lanes off", got, 32'h0);
    bus_read(12'h104, 4'hF, got); chk("R4 upper read keeps", got, 32'h20);
    bus_read(12'h124, 4'h1, got); chk("R4 lane0 read value", got, 32'h80);
    bus_read(12'h104, 4'hF, got); chk("R4 cleared", got, 32'h0);
    chk("R8 irq_rx dropped", {31'b0, irq_rx}, 32'h0);

    // R7/R8 masking alignment bit
    pulse(2, 128);
    bus_read(12'h104, 4'hF, got); chk("R3 align bit6", got, 32'h40);
    bus_write(12'h10C, 4'h1, 32'h40);
    chk("R8 masked", {31'b0, irq_rx}, 32'h0);
    bus_read(12'h128, 4'hF, got); chk("R2 align count", got, 32'h80);

    // R5 set wins over same-cycle clear
    pulse(0, 127);
    @(negedge clk);
    ev_uc = 1'b1; addr = 12'h120; be = 4'h1; rd = 1'b1;
    @(negedge clk);
    ev_uc = 1'b0; rd = 1'b0;
    chk("R5 read value", rdata, 32'h7F);
    bus_read(12'h104, 4'hF, got); chk("R5 bit17 kept", got, 32'h0002_0000);
    chk("R8 irq_rx unicast", {31'b0, irq_rx}, 32'h1);

    // transmit side, R6 write ignored, R2 wrap
    pulse(3, 128);
    bus_read(12'h108, 4'hF, got); chk("R3 tx bit21", got, 32'h0020_0000);
    chk("R8 irq_tx high", {31'b0, irq_tx}, 32'h1);
    bus_write(12'h108, 4'hF, 32'h0);
    bus_read(12'h108, 4'hF, got); chk("R6 write ignored", got, 32'h0020_0000);
    pulse(3, 128);
    bus_read(12'h12C, 4'hF, got); chk("R2 wrap to zero", got, 32'h0);
    bus_read(12'h108, 4'hF, got); chk("R4 tx cleared", got, 32'h0);
    chk("R8 irq_tx dropped", {31'b0, irq_tx}, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule